// File: doc/BRIEF.md
# Fractional-Prescaler Baud Clock Generator

This block derives the timing strobes for a serial port from the system clock. The system clock first passes through a prescaler whose divide factor is picked by a small select code. The factor can be a whole number or a whole number plus one half. The prescaler strobe then drives an integer divisor. Software programs this divisor with one less than the wanted ratio. The divisor output is the 16x oversample strobe. A last fixed stage divides that strobe to give the bit strobe. This stage divides by sixteen when the port runs asynchronously and by two when it runs synchronously. The bit rate is therefore the clock frequency divided by (16 × N × P) in asynchronous mode and by (2 × N × P) in synchronous mode.

Both outputs are single-cycle enables in the input clock domain. No derived clock is created. A half-integer factor k.5 is built from prescaler periods that alternate between k and k+1 input cycles, starting with the shorter one. The average period is therefore exact, and only the rising clock edge is used. A change on any configuration input clears every counter in the cycle where the change is first seen. The strobes are held low in that cycle, so the next period after a change is always a full one.

Top module: `baud_gen`

## Requirements
- R1: While rst_n is low, os_tick and bit_tick stay low whatever the configuration inputs are.
- R2: A prescaler select code of 0 stops the chain: os_tick and bit_tick never assert.
- R3: A select code c from 1 to 31 gives a prescaler factor P = (c+1)/2. Code 1 is 1, code 3 is 2, code 4 is 2.5, code 12 is 6.5 and code 31 is 16. When P is an integer, every prescaler period is exactly P cycles.
- R4: When P = k + 0.5, the prescaler periods alternate k, k+1, k, ..., beginning with k after a restart. Two consecutive oversample periods therefore total 2·N·P cycles.
- R5: div_val holds N−1 on an 11-bit field (0 to 2047). The oversample strobe fires once every N prescaler strobes, so a value of 5 divides by 6 and a value of 1046 divides by 1047.
- R6: With sync_mode = 0, bit_tick fires on every 16th os_tick, in the same cycle as that os_tick. The first bit_tick comes 16·N·P cycles after a restart.
- R7: With sync_mode = 1, bit_tick fires on every 2nd os_tick, in the same cycle as that os_tick.
- R8: A change of presc_sel, div_val or sync_mode restarts all counters, and no strobe asserts in that cycle. If a change is driven just after a falling clock edge, the first os_tick is seen at the falling edge that is exactly one full first oversample period later, counting from the change.
- R9: Each strobe is a one-cycle pulse. bit_tick never asserts in two consecutive cycles and never asserts without os_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every counter advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 5 | Prescaler select code; 0 turns the chain off, c gives P = (c+1)/2 |
| div_val | input | 11 | Baud divisor programmed as N−1 |
| sync_mode | input | 1 | 0 selects a final divide of 16, 1 selects a final divide of 2 |
| os_tick | output | 1 | One-cycle oversample strobe, once per N·P clock cycles on average |
| bit_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
On every cycle, the assertions check that:
- both counters stay inside the limits currently programmed;
- nothing strobes while the prescaler is off or during a restart cycle;
- bit_tick is always a lone pulse that coincides with os_tick.

Only the directed scenarios can show the cycle-exact periods. These include the k/k+1 alternation for half-integer factors, the N−1 offset across the full 11-bit range, and the sixteen-versus-two final ratio. They also show that the first period after a mid-run reprogramming is a full one.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned SEL_W    = 5;
  localparam int unsigned DIV_W    = 11;
  localparam int unsigned OS_ASYNC = 16;
  localparam int unsigned OS_SYNC  = 2;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } baud_mode_e;

  // Select code c maps to a factor of (c+1) half-cycles.
  function automatic logic [SEL_W:0] sel_to_halves(input logic [SEL_W-1:0] sel);
    return {1'b0, sel} + {{SEL_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/bg_change_det.sv
module bg_change_det #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg,
  output logic         restart
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  assign restart = (cfg != cfg_q);
endmodule

// File: rtl/bg_frac_prescaler.sv
module bg_frac_prescaler
  import baud_gen_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int unsigned CW = SW + 1;

  logic [SW:0]   halves;
  logic [SW-1:0] base;
  logic          odd;
  logic          phase;
  logic [CW-1:0] len;
  logic [CW-1:0] cnt;
  logic          enabled;

  always_comb begin
    halves  = {1'b0, sel} + {{SW{1'b0}}, 1'b1};
    base    = halves[SW:1];
    odd     = halves[0];
    len     = {1'b0, base} + {{SW{1'b0}}, odd & phase};
    enabled = (sel != '0);
    tick    = enabled && !restart && (cnt == len - {{SW{1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart || !enabled) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= odd ? ~phase : 1'b0;
    end else begin
      cnt   <= cnt + {{SW{1'b0}}, 1'b1};
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !restart) |-> (cnt < len))
    else $error("prescaler count beyond period length");

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !tick)
    else $error("prescaler strobe while disabled");
endmodule

// File: rtl/bg_int_divider.sv
module bg_int_divider #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         in_tick,
  input  logic [W-1:0] limit,
  output logic         out_tick
);
  logic [W-1:0] cnt;

  assign out_tick = in_tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (in_tick) cnt <= out_tick ? '0 : cnt + {{(W-1){1'b0}}, 1'b1};
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt <= limit))
    else $error("divider count beyond limit");
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int unsigned SW  = SEL_W,
  parameter int unsigned DW  = DIV_W,
  parameter int unsigned OSA = OS_ASYNC,
  parameter int unsigned OSS = OS_SYNC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] presc_sel,
  input  logic [DW-1:0] div_val,
  input  logic          sync_mode,
  output logic          os_tick,
  output logic          bit_tick
);
  localparam int unsigned FW    = (OSA > 2) ? $clog2(OSA) : 1;
  localparam int unsigned CFG_W = SW + DW + 1;

  logic          restart;
  logic          presc_tick;
  logic [FW-1:0] rate_lim;
  baud_mode_e    mode;

  assign mode     = baud_mode_e'(sync_mode);
  assign rate_lim = (mode == MODE_SYNC) ? FW'(OSS - 1) : FW'(OSA - 1);

  bg_change_det #(.W(CFG_W)) u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     ({presc_sel, div_val, sync_mode}),
    .restart (restart)
  );

  bg_frac_prescaler #(.SW(SW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (presc_sel),
    .tick    (presc_tick)
  );

  bg_int_divider #(.W(DW)) u_baud_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .in_tick  (presc_tick),
    .limit    (div_val),
    .out_tick (os_tick)
  );

  bg_int_divider #(.W(FW)) u_rate_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .in_tick  (os_tick),
    .limit    (rate_lim),
    .out_tick (bit_tick)
  );

  p_bit_with_os_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick)
    else $error("bit strobe without oversample strobe");

  p_sel_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_sel == '0) |-> (!os_tick && !bit_tick))
    else $error("strobe with prescaler off");

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!os_tick && !bit_tick))
    else $error("strobe in restart cycle");

  p_bit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick)
    else $error("bit strobe wider than one cycle");
endmodule

// File: tb/baud_gen_tb.sv
`timescale 1ns/1ps
module baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  sel = '0;
  logic [10:0] div = '0;
  logic        mode = 1'b0;
  logic        os_tick, bit_tick;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .presc_sel(sel), .div_val(div),
    .sync_mode(mode), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int f_os, s_os, f_bit, n_os, n_bit, orphan, dbl;

  task automatic run_cfg(input logic [4:0] s, input logic [10:0] d, input logic m, input int n);
    bit prev_bit;
    @(negedge clk);
    sel = s; div = d; mode = m;
    f_os = -1; s_os = -1; f_bit = -1; n_os = 0; n_bit = 0; orphan = 0; dbl = 0;
    prev_bit = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (os_tick) begin
        n_os++;
        if (f_os < 0) f_os = i;
        else if (s_os < 0) s_os = i;
      end
      if (bit_tick) begin
        n_bit++;
        if (f_bit < 0) f_bit = i;
        if (!os_tick) orphan++;
        if (prev_bit) dbl++;
      end
      prev_bit = bit_tick;
    end
  endtask

  task automatic t_reset();
    sel = 5'd1; div = '0; mode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!os_tick && !bit_tick, "R1 reset quiet", {os_tick, bit_tick}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_off();
    run_cfg(5'd0, 11'd5, 1'b0, 300);
    check(n_os == 0, "R2 no os with code 0", n_os, 0);
    check(n_bit == 0, "R2 no bit with code 0", n_bit, 0);
  endtask

  task automatic t_int_presc();
    run_cfg(5'd3, 11'd5, 1'b0, 200);   // P=2, N=6
    check(f_os == 12, "R3 R5 R8 first os", f_os, 12);
    check(s_os == 24, "R3 second os", s_os, 24);
    check(f_bit == 192, "R6 first bit async", f_bit, 192);
    check(n_os == 16, "R9 os pulse count", n_os, 16);
    check(orphan == 0 && dbl == 0, "R9 bit pulse shape", orphan + dbl, 0);
  endtask

  task automatic t_half_presc();
    run_cfg(5'd4, 11'd4, 1'b0, 210);   // P=2.5, N=5: 2,3,2,3,2 then 3,2,3,2,3
    check(f_os == 12, "R4 first os half factor", f_os, 12);
    check(s_os == 25, "R4 second os half factor", s_os, 25);
    check(f_bit == 200, "R6 first bit half factor", f_bit, 200);
  endtask

  task automatic t_sync();
    run_cfg(5'd12, 11'd1, 1'b1, 60);   // P=6.5, N=2
    check(f_os == 13, "R4 first os P=6.5", f_os, 13);
    check(s_os == 26, "R4 second os P=6.5", s_os, 26);
    check(f_bit == 26, "R7 first bit sync", f_bit, 26);
    check(n_bit == 2, "R7 bit count sync", n_bit, 2);
    check(orphan == 0, "R7 bit with os", orphan, 0);
  endtask

  task automatic t_unit();
    run_cfg(5'd1, 11'd0, 1'b0, 40);    // P=1, N=1
    check(n_os == 40, "R5 os every cycle", n_os, 40);
    check(f_bit == 16, "R6 bit after 16 os", f_bit, 16);
    check(n_bit == 2 && dbl == 0, "R9 bit single pulses", n_bit, 2);
  endtask

  task automatic t_restart();
    run_cfg(5'd3, 11'd5, 1'b0, 7);
    run_cfg(5'd3, 11'd2, 1'b0, 30);    // N=3, P=2
    check(f_os == 6, "R8 full first period after divisor change", f_os, 6);
    check(s_os == 12, "R8 second period", s_os, 12);
    run_cfg(5'd3, 11'd2, 1'b1, 30);
    check(f_os == 6, "R8 restart on mode change", f_os, 6);
    check(f_bit == 12, "R7 sync bit after mode change", f_bit, 12);
  endtask

  task automatic t_wide_div();
    run_cfg(5'd2, 11'd1046, 1'b0, 1600);   // P=1.5, N=1047
    check(f_os == 1570, "R5 wide divisor", f_os, 1570);
    check(n_os == 1, "R5 single os in window", n_os, 1);
  endtask

  initial begin
    t_reset();
    t_off();
    t_int_presc();
    t_half_presc();
    t_sync();
    t_unit();
    t_restart();
    t_wide_div();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule